// File: doc/BRIEF.md
# Read Burst Beat Sequencer

This block is the read side of a memory-mapped slave. It takes one request on an address handshake: a start address, a transaction tag, a beat count, a beat size and a burst kind. From that single address it generates the address of every beat internally. It then returns the beats in order on a data channel with a valid/ready handshake, and flags the final beat.

The three burst kinds are constant address, stepping address and wrap-around inside an aligned window. The returned data is a pattern derived from the beat address and the tag. This lets a requester or an interconnect test check every beat without a real memory behind the slave. Once a burst starts, it always runs to its full beat count. A new request is taken only after the final beat has been accepted.

Top module: `burst_rd_engine`

## Requirements
- R1: A request is taken on a rising edge where `ar_valid` and `ar_ready` are both high. On the next cycle `r_valid` is high, `r_addr` equals the start address exactly (unaligned start allowed), and `r_id` equals `ar_id`.
- R2: A burst has `ar_len`+1 beats (`ar_len` 0..15). `r_last` is high on the final beat only, and the burst always runs to its full count.
- R3: Burst kind code 0 (constant) presents the start address on every beat.
- R4: Burst kind code 1 (stepping) gives each beat after the first the address of the previous beat rounded down to a multiple of the beat size, plus the beat size, modulo 2^ADDR_W. Code 3 behaves identically.
- R5: Burst kind code 2 (wrap), with a beat count of 2, 4, 8 or 16, uses a window W = beats × beat size. Each next address keeps the bits above W-1 of the current address, and its low bits (mask W-1) are taken from the stepping result of R4.
- R6: Burst kind code 2 with any other beat count is executed as a stepping burst (R4).
- R7: The beat size is 2^`ar_size` bytes. Values above log2(DATA_W/8) are treated as that maximum.
- R8: While `r_valid` is high and `r_ready` is low, `r_valid`, `r_addr`, `r_id`, `r_last` and `r_data` hold their values.
- R9: After reset `ar_ready` is high and `r_valid` low. `ar_ready` is low from the accepting edge until the edge that accepts the final beat, and high in the following cycle. A request offered meanwhile is ignored.
- R10: Every beat of a burst carries the tag given with its request.
- R11: `r_data` equals the zero-extended `r_addr` XOR the tag placed in the top ID_W bits.

Port rows for `burst_rd_engine`, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_valid | input | 1 | Request offered |
| ar_ready | output | 1 | Engine idle, request can be taken |
| ar_addr | input | ADDR_W | Start byte address |
| ar_id | input | ID_W | Transaction tag |
| ar_len | input | LEN_W | Beat count minus one |
| ar_size | input | SIZE_W | log2 of bytes per beat |
| ar_burst | input | 2 | Burst kind: 0 constant, 1 stepping, 2 wrap, 3 stepping |
| r_valid | output | 1 | Beat presented |
| r_ready | input | 1 | Beat accepted |
| r_addr | output | ADDR_W | Address of the current beat |
| r_data | output | DATA_W | Pattern data of the current beat |
| r_id | output | ID_W | Tag of the current burst |
| r_last | output | 1 | Final beat of the burst |

## Verification
The bench sweeps every burst kind, every beat count from 1 to 16 and every size including one beyond the data width. It uses an unaligned start address and a start address just below the top of the address space. With this sweep, a sequencer that wraps at the wrong window edge, forgets to round an unaligned address, or lets an illegal wrap length fall into wrap mode produces a wrong beat address at once. So does a sequencer that mishandles address overflow.

Back-pressure is applied on a rotating set of beats, while a rival request is offered at the same time. A design that advanced on a stall would skip an address or move `r_last` early. A design that took the rival request mid-burst would corrupt the tag or address. The bench also checks that `ar_ready` returns exactly one cycle after the final beat, so an off-by-one in the beat counter shows up as a missing or extra beat.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        BK_CONST = 2'd0,
        BK_STEP  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4,
    parameter int SIZE_W = 3,
    parameter int MAX_SIZE = 2
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size_in,
    input  logic [1:0]        kind_in,
    output logic [SIZE_W-1:0] size_eff,
    output burst_kind_e       kind_eff,
    output logic [ADDR_W-1:0] wrap_mask
);
    localparam int BEATS_W = LEN_W + 1;

    logic [BEATS_W-1:0] beats;
    logic               pow2;
    int                 beats_lg;
    int                 win_lg;

    always_comb begin
        beats = {1'b0, len} + BEATS_W'(1);
        pow2  = (beats >= BEATS_W'(2)) && ((beats & (beats - BEATS_W'(1))) == '0);

        beats_lg = 0;
        for (int i = 0; i < BEATS_W; i++) begin
            if (beats == (BEATS_W'(1) << i)) beats_lg = i;
        end

        if (size_in > SIZE_W'(MAX_SIZE)) size_eff = SIZE_W'(MAX_SIZE);
        else                             size_eff = size_in;

        unique case (kind_in)
            2'd0:    kind_eff = BK_CONST;
            2'd2:    kind_eff = pow2 ? BK_WRAP : BK_STEP;
            default: kind_eff = BK_STEP;
        endcase

        win_lg    = int'(size_eff) + beats_lg;
        wrap_mask = (ADDR_W'(1) << win_lg) - ADDR_W'(1);
    end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size,
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] bytes;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        bytes   = ADDR_W'(1) << size;
        aligned = cur_addr & ~(bytes - ADDR_W'(1));
        stepped = aligned + bytes;
        unique case (kind)
            BK_CONST: next_addr = cur_addr;
            BK_WRAP:  next_addr = (cur_addr & ~wrap_mask) | (stepped & wrap_mask);
            default:  next_addr = stepped;
        endcase
    end
endmodule

// File: rtl/burst_pattern.sv
module burst_pattern #(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   id,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] id_word;

    always_comb begin
        id_word = '0;
        id_word[DATA_W-1 -: ID_W] = id;
        data = DATA_W'(addr) ^ id_word;
    end
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int LEN_W  = 4,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [LEN_W-1:0]  ar_len,
    input  logic [SIZE_W-1:0] ar_size,
    input  logic [1:0]        ar_burst,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ADDR_W-1:0] r_addr,
    output logic [DATA_W-1:0] r_data,
    output logic [ID_W-1:0]   r_id,
    output logic              r_last
);
    localparam int MAX_SIZE = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic [SIZE_W-1:0] size;
        burst_kind_e       kind;
        logic [ADDR_W-1:0] mask;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
    } eng_state_t;

    eng_state_t st_q, st_d;

    logic [SIZE_W-1:0] dec_size;
    burst_kind_e       dec_kind;
    logic [ADDR_W-1:0] dec_mask;
    logic [ADDR_W-1:0] step_addr;
    logic              final_beat;

    burst_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)
    ) u_decode (
        .len      (ar_len),
        .size_in  (ar_size),
        .kind_in  (ar_burst),
        .size_eff (dec_size),
        .kind_eff (dec_kind),
        .wrap_mask(dec_mask)
    );

    burst_addr_step #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
    ) u_step (
        .cur_addr (st_q.addr),
        .size     (st_q.size),
        .kind     (st_q.kind),
        .wrap_mask(st_q.mask),
        .next_addr(step_addr)
    );

    burst_pattern #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)
    ) u_pattern (
        .addr(st_q.addr),
        .id  (st_q.id),
        .data(r_data)
    );

    always_comb begin
        st_d       = st_q;
        final_beat = (st_q.cnt == st_q.len);
        if (!st_q.busy) begin
            if (ar_valid) begin
                st_d.busy = 1'b1;
                st_d.addr = ar_addr;
                st_d.id   = ar_id;
                st_d.size = dec_size;
                st_d.kind = dec_kind;
                st_d.mask = dec_mask;
                st_d.cnt  = '0;
                st_d.len  = ar_len;
            end
        end else if (r_ready) begin
            if (final_beat) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.addr = step_addr;
                st_d.cnt  = st_q.cnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, addr: '0, id: '0, size: '0, kind: BK_CONST,
                      mask: '0, cnt: '0, len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ar_ready = !st_q.busy;
    assign r_valid  = st_q.busy;
    assign r_addr   = st_q.addr;
    assign r_id     = st_q.id;
    assign r_last   = st_q.busy && final_beat;
endmodule

// File: rtl/burst_rd_checker.sv
module burst_rd_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int LEN_W  = 4,
    parameter int SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic [ID_W-1:0]   ar_id,
    input logic [LEN_W-1:0]  ar_len,
    input logic [SIZE_W-1:0] ar_size,
    input logic [1:0]        ar_burst,
    input logic              r_valid,
    input logic              r_ready,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_data,
    input logic [ID_W-1:0]   r_id,
    input logic              r_last
);
    logic [LEN_W-1:0]  cap_len;
    logic [LEN_W-1:0]  seen;
    logic [1:0]        cap_kind;
    logic [ID_W-1:0]   cap_id;
    logic [ADDR_W-1:0] cap_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_len  <= '0;
            seen     <= '0;
            cap_kind <= '0;
            cap_id   <= '0;
            cap_addr <= '0;
        end else if (ar_valid && ar_ready) begin
            cap_len  <= ar_len;
            seen     <= '0;
            cap_kind <= ar_burst;
            cap_id   <= ar_id;
            cap_addr <= ar_addr;
        end else if (r_valid && r_ready) begin
            seen <= seen + LEN_W'(1);
        end
    end

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && ar_ready |=> r_valid && r_addr == $past(ar_addr) && r_id == $past(ar_id)); // R1
    AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_last == (seen == cap_len))); // R2
    AST_CONST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && cap_kind == 2'd0 |-> r_addr == cap_addr); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && !r_ready |=> r_valid && $stable(r_addr) && $stable(r_last) && $stable(r_data) && $stable(r_id)); // R8
    AST_AR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> !ar_ready); // R9
    AST_AR_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid && r_ready && r_last |=> ar_ready && !r_valid); // R9
    AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> r_id == cap_id); // R10
    AST_DATA_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> r_data[DATA_W-1 -: ID_W] == (cap_id ^ ID_W'(r_addr >> (DATA_W - ID_W)))); // R11

    logic unused_ok;
    assign unused_ok = ^{ar_size};
endmodule

bind burst_rd_engine burst_rd_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
    .ar_burst(ar_burst), .r_valid(r_valid), .r_ready(r_ready), .r_addr(r_addr),
    .r_data(r_data), .r_id(r_id), .r_last(r_last)
);

// File: tb/sim_burst_rd_engine.sv
`timescale 1ns/1ps
module sim_burst_rd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ar_valid = 1'b0;
    logic        ar_ready;
    logic [15:0] ar_addr = '0;
    logic [3:0]  ar_id = '0;
    logic [3:0]  ar_len = '0;
    logic [2:0]  ar_size = '0;
    logic [1:0]  ar_burst = '0;
    logic        r_valid;
    logic        r_ready = 1'b0;
    logic [15:0] r_addr;
    logic [31:0] r_data;
    logic [3:0]  r_id;
    logic        r_last;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_rd_engine u0 (
        .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
        .ar_burst(ar_burst), .r_valid(r_valid), .r_ready(r_ready), .r_addr(r_addr),
        .r_data(r_data), .r_id(r_id), .r_last(r_last)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] next_addr(input logic [15:0] a, input int kind, input int size, input int len);
        int sz;
        int bytes;
        int beats;
        int k;
        logic [15:0] al;
        logic [15:0] inc;
        logic [15:0] m;
        sz = (size > 2) ? 2 : size;
        bytes = 1 << sz;
        beats = len + 1;
        k = kind;
        if (k == 3) k = 1;
        if (k == 2 && !(beats == 2 || beats == 4 || beats == 8 || beats == 16)) k = 1;
        al = a & ~16'(bytes - 1);
        inc = al + 16'(bytes);
        if (k == 0) return a;
        if (k == 1) return inc;
        m = 16'(bytes * beats - 1);
        return (a & ~m) | (inc & m);
    endfunction

    function automatic string addr_tag(input int kind, input int size, input int len);
        int beats;
        beats = len + 1;
        if (size > 2) return "R7";
        if (kind == 0) return "R3";
        if (kind == 2 && (beats == 2 || beats == 4 || beats == 8 || beats == 16)) return "R5";
        if (kind == 2) return "R6";
        return "R4";
    endfunction

    task automatic run_burst(input logic [15:0] a, input int kind, input int size, input int len, input logic [3:0] id);
        logic [15:0] ea;
        logic [31:0] ed;
        string tg;
        tg = addr_tag(kind, size, len);
        @(negedge clk);
        chk(ar_ready === 1'b1, "R9", 32'(ar_ready), 32'd1);
        ar_valid = 1'b1;
        ar_addr  = a;
        ar_id    = id;
        ar_len   = 4'(len);
        ar_size  = 3'(size);
        ar_burst = 2'(kind);
        @(negedge clk);
        ar_valid = 1'b0;
        ea = a;
        for (int b = 0; b <= len; b++) begin
            ed = {16'h0, ea} ^ {id, 28'h0};
            chk(r_valid === 1'b1, "R2", 32'(r_valid), 32'd1);
            chk(r_addr === ea, (b == 0) ? "R1" : tg, 32'(r_addr), 32'(ea));
            chk(r_last === (b == len), "R2", 32'(r_last), 32'(b == len));
            chk(r_id === id, "R10", 32'(r_id), 32'(id));
            chk(r_data === ed, "R11", r_data, ed);
            chk(ar_ready === 1'b0, "R9", 32'(ar_ready), 32'd0);
            if ((b + len) % 3 == 0) begin
                r_ready  = 1'b0;
                ar_valid = 1'b1;
                ar_addr  = ~a;
                ar_id    = ~id;
                @(negedge clk);
                ar_valid = 1'b0;
                chk(r_valid === 1'b1, "R8", 32'(r_valid), 32'd1);
                chk(r_addr === ea, "R8", 32'(r_addr), 32'(ea));
                chk(r_last === (b == len), "R8", 32'(r_last), 32'(b == len));
                chk(r_id === id, "R9", 32'(r_id), 32'(id));
            end
            r_ready = 1'b1;
            @(negedge clk);
            r_ready = 1'b0;
            ea = next_addr(ea, kind, size, len);
        end
        chk(r_valid === 1'b0, "R2", 32'(r_valid), 32'd0);
        chk(ar_ready === 1'b1, "R9", 32'(ar_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ar_ready === 1'b1, "R9", 32'(ar_ready), 32'd1);
        chk(r_valid === 1'b0, "R9", 32'(r_valid), 32'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 2; s++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int size = 0; size < 4; size++) begin
                    for (int len = 0; len < 16; len++) begin
                        run_burst((s == 0) ? 16'h1235 : 16'hFFE8, kind, size, len,
                                  4'(len ^ (kind * 5) ^ s));
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule